// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small fully associative store of finished address translations placed in front of a page-table walker. A lookup presents a virtual page number (virtual address bits 47:12) and receives, one cycle later, a hit or miss together with the physical frame of the 4 KB page, the page size of the entry and the low attribute bits of the leaf entry. On a miss the walker resolves the translation, which can cost as many as four dependent memory reads, and installs the result through the fill port.

One array holds 4 KB, 2 MB and 1 GB entries side by side. A large entry covers its whole page, so its compare ignores the low page-number bits. Control inputs remove the entry covering a single page, or flush the array when the root table register is reloaded. Entries marked global survive a flush. With context tagging enabled, each entry keeps the 12-bit context identifier that was current at fill time, and a reload clears only the non-global entries of the context being loaded. An entry whose backing table changes in memory keeps answering until it is removed explicitly.

Top module: `tlb_tagged`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high, `rsp_hit` is never high without `rsp_valid`, and after reset no entry is valid, so every lookup misses.
- R2: An entry hits when it is valid and its page number equals the lookup page number under its size mask. Size code 0 is 4 KB and compares all bits, code 1 is 2 MB and ignores page-number bits 8:0, code 2 is 1 GB and ignores bits 17:0, and code 3 is treated as 4 KB.
- R3: On a hit, `rsp_pfn` is the frame of the 4 KB page. For a 2 MB entry its bits 8:0 come from the lookup page number, and for a 1 GB entry its bits 17:0 do. `rsp_size` and `rsp_attr` return the values that were filled.
- R4: With `ctx_en` high, a non-global entry hits only when its stored context equals `ctx_id`. An entry whose attribute bit 8 (global) is set hits under any context. With `ctx_en` low the context is not compared.
- R5: A filled entry can be found from the cycle after the fill. A lookup in the same cycle as the fill does not see it.
- R6: `inv_en` removes every entry whose page range covers `inv_vpn`, whatever its context, and leaves all other entries in place.
- R7: `root_load` with `ctx_en` low removes every non-global entry and keeps the global ones.
- R8: `root_load` with `ctx_en` high removes only the non-global entries tagged with the current `ctx_id`. Entries of other contexts and global entries stay.
- R9: A lookup in the same cycle as an invalidate or flush that removes the matching entry returns a miss.
- R10: A fill takes the lowest-index invalid slot. If every slot is valid, the fill takes the slot at a round-robin pointer, which starts at 0 after reset and steps by one (wrapping after the last slot) only when it is used.
- R11: When several entries match a lookup, the lowest-index entry answers.
- R12: When a fill falls in the same cycle as an invalidate or flush, the victim is chosen from the slot validity before the removal. The removal applies to the old contents, and the new entry is installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_en | input | 1 | Enables context-tagged matching and flushing |
| ctx_id | input | 12 | Current context identifier (low bits of the root register) |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 36 | Lookup virtual page number (VA bits 47:12) |
| fill_en | input | 1 | Install a walker result |
| fill_vpn | input | 36 | Page number of the installed entry |
| fill_pfn | input | 36 | Frame number of the installed entry |
| fill_size | input | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fill_attr | input | 12 | Low attribute bits of the leaf entry; bit 8 marks the entry global |
| inv_en | input | 1 | Single-page invalidate |
| inv_vpn | input | 36 | Page number to invalidate |
| root_load | input | 1 | Root register reload (flush) |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | 36 | Frame number of the 4 KB page looked up |
| rsp_size | output | 2 | Page size code of the hit entry |
| rsp_attr | output | 12 | Attribute bits of the hit entry |

## Verification
A lookup and a removal of the same entry can fall in one cycle, and so can a fill and a removal. The bench provokes the first directly, by presenting an invalidate for the page being looked up and a flush while a context's entries are queried. It provokes the second through random traffic in which fills, invalidates and reloads overlap on a small pool of page numbers. A bench model applies the removals to the old contents before it resolves the lookup or places the fill, and the response is judged against that model's hit, frame, size and attributes.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int unsigned VPN_W   = 36;
    localparam int unsigned PFN_W   = 36;
    localparam int unsigned CTX_W   = 12;
    localparam int unsigned ATTR_W  = 12;
    localparam int unsigned GLB_BIT = 8;
    localparam int unsigned MID_LOW = 9;   // page-number bits covered by a 2 MB page
    localparam int unsigned BIG_LOW = 18;  // page-number bits covered by a 1 GB page

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [CTX_W-1:0]  ctx;
        pg_size_e          size;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    // Bits of the page number that take part in the tag compare.
    function automatic logic [VPN_W-1:0] vpn_keep(pg_size_e s);
        logic [VPN_W-1:0] m;
        unique case (s)
            PG_2M:   m = {{(VPN_W-MID_LOW){1'b1}}, {MID_LOW{1'b0}}};
            PG_1G:   m = {{(VPN_W-BIG_LOW){1'b1}}, {BIG_LOW{1'b0}}};
            default: m = '1;
        endcase
        return m;
    endfunction

    // Bits of the frame number taken from the entry rather than the lookup.
    function automatic logic [PFN_W-1:0] pfn_keep(pg_size_e s);
        logic [PFN_W-1:0] m;
        unique case (s)
            PG_2M:   m = {{(PFN_W-MID_LOW){1'b1}}, {MID_LOW{1'b0}}};
            PG_1G:   m = {{(PFN_W-BIG_LOW){1'b1}}, {BIG_LOW{1'b0}}};
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
    import tlb_pkg::*;
(
    input  logic             vld,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [CTX_W-1:0] e_ctx,
    input  pg_size_e         e_size,
    input  logic             e_glob,
    input  logic [VPN_W-1:0] vpn,
    input  logic [CTX_W-1:0] ctx_id,
    input  logic             ctx_chk,
    output logic             match
);
    logic [VPN_W-1:0] keep;
    logic             tag_eq;
    logic             ctx_ok;

    always_comb begin
        keep   = vpn_keep(e_size);
        tag_eq = ((e_vpn ^ vpn) & keep) == '0;
        ctx_ok = !ctx_chk || e_glob || (e_ctx == ctx_id);
        match  = vld && tag_eq && ctx_ok;
    end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N_ENT-1:0] vld,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim,
    output logic             full
);
    always_comb begin
        full   = &vld;
        victim = rr_ptr;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!vld[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_tagged.sv
`timescale 1ns/1ps
module tlb_tagged
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_en,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_size,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              root_load,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [1:0]        rsp_size,
    output logic [ATTR_W-1:0] rsp_attr
);
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    tlb_ent_t         ents_q [N_ENT];
    logic [N_ENT-1:0] valid_q, valid_d;
    logic [N_ENT-1:0] glob_vec, look_hit, inv_raw, flush_sel, kill, hit_vec;
    logic [IDX_W-1:0] rr_q, victim, hit_idx;
    logic             tbl_full, any_hit;
    tlb_ent_t         hit_ent;
    logic [PFN_W-1:0] frame_d;

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        assign glob_vec[g] = ents_q[g].attr[GLB_BIT];

        tlb_match u_look (
            .vld(valid_q[g]), .e_vpn(ents_q[g].vpn), .e_ctx(ents_q[g].ctx),
            .e_size(ents_q[g].size), .e_glob(glob_vec[g]),
            .vpn(lk_vpn), .ctx_id(ctx_id), .ctx_chk(ctx_en), .match(look_hit[g])
        );

        tlb_match u_inv (
            .vld(valid_q[g]), .e_vpn(ents_q[g].vpn), .e_ctx(ents_q[g].ctx),
            .e_size(ents_q[g].size), .e_glob(glob_vec[g]),
            .vpn(inv_vpn), .ctx_id(ctx_id), .ctx_chk(1'b0), .match(inv_raw[g])
        );

        assign flush_sel[g] = root_load && valid_q[g] && !glob_vec[g] &&
                              (!ctx_en || (ents_q[g].ctx == ctx_id));
    end

    // Removals of this cycle act on the old contents and hide the entry
    // from a lookup in the same cycle.
    assign kill    = ({N_ENT{inv_en}} & inv_raw) | flush_sel;
    assign hit_vec = look_hit & ~kill;

    always_comb begin
        any_hit = |hit_vec;
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
        hit_ent = ents_q[hit_idx];
        frame_d = (hit_ent.pfn & pfn_keep(hit_ent.size)) |
                  (PFN_W'(lk_vpn) & ~pfn_keep(hit_ent.size));
    end

    tlb_victim #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_victim (
        .vld(valid_q), .rr_ptr(rr_q), .victim(victim), .full(tbl_full)
    );

    always_comb begin
        valid_d = valid_q & ~kill;
        if (fill_en) valid_d[victim] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            valid_q <= valid_d;
            if (fill_en && tbl_full) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            ents_q[victim] <= '{vpn: fill_vpn, pfn: fill_pfn, ctx: ctx_id,
                               size: pg_size_e'(fill_size), attr: fill_attr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_size  <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && any_hit;
            if (lk_req && any_hit) begin
                rsp_pfn  <= frame_d;
                rsp_size <= hit_ent.size;
                rsp_attr <= hit_ent.attr;
            end
        end
    end
endmodule

// File: rtl/tlb_tagged_chk.sv
`timescale 1ns/1ps
module tlb_tagged_chk
    import tlb_pkg::*;
#(
    parameter int unsigned N_ENT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctx_en,
    input logic             lk_req,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             fill_en,
    input logic             inv_en,
    input logic [VPN_W-1:0] inv_vpn,
    input logic             root_load,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [N_ENT-1:0] valid_q,
    input logic [N_ENT-1:0] glob_vec
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid) else $error("rsp_valid missing"); // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid) else $error("spurious rsp_valid"); // R1
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid) else $error("hit without valid"); // R1
    AST_INV_SAME_PAGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && inv_en && (inv_vpn == lk_vpn)) |=> (rsp_valid && !rsp_hit))
        else $error("hit on page invalidated in same cycle"); // R9
    AST_FLAT_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (root_load && !ctx_en && !fill_en) |=> ((valid_q & ~glob_vec) == '0))
        else $error("non-global entry survived flush"); // R7
    AST_REMOVE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_en || root_load) && !fill_en) |=>
        ($countones(valid_q) <= $past($countones(valid_q))))
        else $error("entries grew during removal"); // R6
endmodule

bind tlb_tagged tlb_tagged_chk #(.N_ENT(N_ENT)) u_tlb_chk (
    .clk(clk), .rst_n(rst_n), .ctx_en(ctx_en), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .fill_en(fill_en), .inv_en(inv_en), .inv_vpn(inv_vpn), .root_load(root_load),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .valid_q(valid_q), .glob_vec(glob_vec)
);

// File: tb/tb_tlb_tagged.sv
`timescale 1ns/1ps
module tb_tlb_tagged;
    import tlb_pkg::*;

    localparam int NE     = 16;
    localparam int WD_CYC = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctx_en = 1'b0;
    logic [CTX_W-1:0]  ctx_id = '0;
    logic              lk_req = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic              fill_en = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [1:0]        fill_size = '0;
    logic [ATTR_W-1:0] fill_attr = '0;
    logic              inv_en = 1'b0;
    logic [VPN_W-1:0]  inv_vpn = '0;
    logic              root_load = 1'b0;
    logic              rsp_valid, rsp_hit;
    logic [PFN_W-1:0]  rsp_pfn;
    logic [1:0]        rsp_size;
    logic [ATTR_W-1:0] rsp_attr;

    always #2.5 clk = ~clk;

    tlb_tagged #(.N_ENT(NE)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the array
    logic              m_vld  [NE];
    logic [VPN_W-1:0]  m_vpn  [NE];
    logic [PFN_W-1:0]  m_pfn  [NE];
    logic [CTX_W-1:0]  m_ctx  [NE];
    logic [1:0]        m_size [NE];
    logic [ATTR_W-1:0] m_attr [NE];
    int                m_rr;

    function automatic int low_bits(logic [1:0] s);
        return (s == 2'd1) ? 9 : (s == 2'd2) ? 18 : 0;
    endfunction

    function automatic bit covers(int i, logic [VPN_W-1:0] v);
        int lb = low_bits(m_size[i]);
        return m_vld[i] && ((m_vpn[i] >> lb) == (v >> lb));
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clr_in();
        lk_req = 0; fill_en = 0; inv_en = 0; root_load = 0;
    endtask

    // One clock: model predicts, design runs, response checked at next negedge.
    // want: -1 no directed expectation, 0 expect miss, 1 expect hit.
    task automatic step(input string tag, input int want);
        bit ex_req, ex_hit;
        logic [PFN_W-1:0] ex_pfn;
        logic [1:0] ex_size;
        logic [ATTR_W-1:0] ex_attr;
        bit kill [NE];
        int vic;
        ex_req = lk_req; ex_hit = 0; ex_pfn = '0; ex_size = '0; ex_attr = '0;
        for (int i = 0; i < NE; i++) begin
            kill[i] = (inv_en && covers(i, inv_vpn)) ||
                      (root_load && m_vld[i] && !m_attr[i][8] && (!ctx_en || m_ctx[i] == ctx_id));
        end
        for (int i = NE - 1; i >= 0; i--) begin
            if (lk_req && !kill[i] && covers(i, lk_vpn) &&
                (!ctx_en || m_attr[i][8] || m_ctx[i] == ctx_id)) begin
                int lb = low_bits(m_size[i]);
                logic [PFN_W-1:0] lm = (PFN_W'(1) << lb) - 1;
                ex_hit  = 1;
                ex_pfn  = (m_pfn[i] & ~lm) | (lk_vpn & lm);
                ex_size = m_size[i];
                ex_attr = m_attr[i];
            end
        end
        vic = -1;
        for (int i = NE - 1; i >= 0; i--) if (!m_vld[i]) vic = i;
        if (fill_en && vic < 0) begin
            vic = m_rr;
            m_rr = (m_rr + 1) % NE;
        end
        for (int i = 0; i < NE; i++) if (kill[i]) m_vld[i] = 0;
        if (fill_en) begin
            m_vld[vic] = 1; m_vpn[vic] = fill_vpn; m_pfn[vic] = fill_pfn;
            m_ctx[vic] = ctx_id; m_size[vic] = fill_size; m_attr[vic] = fill_attr;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == ex_req, {tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'(ex_req));
        if (ex_req) begin
            chk(rsp_hit == ex_hit, {tag, " R2 hit"}, 64'(rsp_hit), 64'(ex_hit));
            if (ex_hit && rsp_hit) begin
                chk(rsp_pfn == ex_pfn, {tag, " R3 pfn"}, 64'(rsp_pfn), 64'(ex_pfn));
                chk(rsp_size == ex_size && rsp_attr == ex_attr, {tag, " R3 size/attr"},
                    64'({rsp_size, rsp_attr}), 64'({ex_size, ex_attr}));
            end
            if (want >= 0)
                chk(rsp_hit == want[0], {tag, " directed"}, 64'(rsp_hit), 64'(want));
        end
        clr_in();
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input int want, input string tag);
        lk_req = 1; lk_vpn = v;
        step(tag, want);
    endtask

    task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                        input logic [1:0] s, input bit glob);
        fill_en = 1; fill_vpn = v; fill_pfn = p; fill_size = s;
        fill_attr = glob ? 12'h125 : 12'h027;
        step("fill", -1);
    endtask

    task automatic do_reset();
        clr_in();
        rst_n = 0;
        for (int i = 0; i < NE; i++) m_vld[i] = 0;
        m_rr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0 && rsp_hit == 0, "R1 reset state", 64'({rsp_valid, rsp_hit}), 64'(0));
    endtask

    initial begin
        #(WD_CYC * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_7175));
        @(negedge clk);
        do_reset();
        look(36'h0, 0, "R1 empty after reset");

        // R5: not visible in the fill cycle, visible after
        lk_req = 1; lk_vpn = 36'h00A_BC123;
        fill_en = 1; fill_vpn = 36'h00A_BC123; fill_pfn = 36'h123456789;
        fill_size = 2'd0; fill_attr = 12'h027;
        step("R5 same-cycle fill", 0);
        look(36'h00A_BC123, 1, "R5 next cycle");

        // R2/R3 large pages
        fill(36'h0005_0200, 36'hABCD_E0000, 2'd1, 0);
        look(36'h0005_03AB, 1, "R2 R3 2MB inner");
        look(36'h0005_0400, 0, "R2 2MB outside");
        fill(36'h0C00_00000 >> 0, 36'h7700_00000, 2'd2, 0);
        look(36'h0C00_2ABCD, 1, "R2 R3 1GB inner");
        fill(36'h0000_0777, 36'h0000_11111, 2'd3, 0);
        look(36'h0000_0776, 0, "R2 code3 as 4KB");

        // R4 contexts
        ctx_en = 1; ctx_id = 12'h001;
        look(36'h00A_BC123, 0, "R4 other context");
        fill(36'h0000_0D00, 36'h0000_0DDDD, 2'd0, 1);
        fill(36'h0000_0E00, 36'h0000_0EEEE, 2'd0, 0);
        ctx_id = 12'h002;
        look(36'h0000_0D00, 1, "R4 global any context");
        look(36'h0000_0E00, 0, "R4 ctx1 entry under ctx2");

        // R8 tagged reload of ctx 0 keeps ctx 1
        ctx_id = 12'h000; root_load = 1; lk_req = 1; lk_vpn = 36'h00A_BC123;
        step("R9 R8 flush same cycle", 0);
        look(36'h0005_0200, 0, "R8 ctx0 removed");
        ctx_id = 12'h001;
        look(36'h0000_0E00, 1, "R8 ctx1 kept");

        // R7 untagged flush
        ctx_en = 0; root_load = 1;
        step("R7 flush", -1);
        look(36'h0000_0E00, 0, "R7 non-global removed");
        look(36'h0000_0D00, 1, "R7 global kept");

        // R9 / R6 invalidate
        lk_req = 1; lk_vpn = 36'h0000_0D00; inv_en = 1; inv_vpn = 36'h0000_0D00;
        step("R9 inv same cycle", 0);
        look(36'h0000_0D00, 0, "R6 entry gone");
        fill(36'h0000_0F01, 36'h1, 2'd0, 0);
        fill(36'h0000_0F02, 36'h2, 2'd0, 0);
        inv_en = 1; inv_vpn = 36'h0000_0F01;
        step("R6 inv", -1);
        look(36'h0000_0F02, 1, "R6 neighbour kept");

        // R10 replacement order
        do_reset();
        for (int i = 0; i < NE; i++) fill(36'(i), 36'(i + 16'h100), 2'd0, 0);
        fill(36'd100, 36'h64, 2'd0, 0);
        look(36'd0, 0, "R10 slot0 replaced");
        look(36'd1, 1, "R10 slot1 kept");
        inv_en = 1; inv_vpn = 36'd5;
        step("R10 free slot5", -1);
        fill(36'd101, 36'h65, 2'd0, 0);
        fill(36'd102, 36'h66, 2'd0, 0);
        look(36'd1, 0, "R10 rr advanced to slot1");
        look(36'd2, 1, "R10 slot2 kept");
        look(36'd101, 1, "R10 invalid slot reused");

        // R12 fill with invalidate on a full array
        inv_en = 1; inv_vpn = 36'd3; fill_en = 1; fill_vpn = 36'd103;
        fill_pfn = 36'h67; fill_size = 2'd0; fill_attr = 12'h027;
        step("R12 fill+inv", -1);
        look(36'd103, 1, "R12 fill installed");
        look(36'd2, 0, "R12 rr victim used");
        look(36'd3, 0, "R12 inv applied");

        // R11 duplicate entries
        do_reset();
        fill(36'h42, 36'hAAA, 2'd0, 0);
        fill(36'h42, 36'hBBB, 2'd0, 0);
        lk_req = 1; lk_vpn = 36'h42;
        step("R11 lowest index", 1);

        // constrained random traffic
        for (int n = 0; n < 5000; n++) begin
            logic [VPN_W-1:0] v;
            if (n % 64 == 0) ctx_en = $urandom_range(0, 1);
            ctx_id = 12'($urandom_range(0, 2));
            v = (36'($urandom_range(0, 3)) << 18) | (36'($urandom_range(0, 3)) << 9) |
                36'($urandom_range(0, 3));
            lk_req = ($urandom_range(0, 9) < 7);
            lk_vpn = v;
            if ($urandom_range(0, 9) < 3) begin
                fill_en = 1;
                fill_vpn = (36'($urandom_range(0, 3)) << 18) | (36'($urandom_range(0, 3)) << 9) |
                           36'($urandom_range(0, 3));
                fill_pfn = {4'($urandom), 32'($urandom)};
                fill_size = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
                fill_attr = 12'($urandom) & ~12'h100 | (($urandom_range(0, 5) == 0) ? 12'h100 : 12'h0);
            end
            if ($urandom_range(0, 19) == 0) begin
                inv_en = 1;
                inv_vpn = ($urandom_range(0, 1) == 0) ? v :
                          (36'($urandom_range(0, 3)) << 18) | 36'($urandom_range(0, 3));
            end
            root_load = ($urandom_range(0, 39) == 0);
            step("rnd R4 R6 R8 R12", -1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule